// File: doc/BRIEF.md
# Read-Only Victim Buffer

The block sits beside a sectored last-level cache and catches lines that the cache evicts while they are marked read-only. Each eviction is sorted sector by sector. Sectors that are valid and dirty go to the write-back output toward memory. Clean sectors of an ordinary line are dropped. A clean read-only line is kept in a small fully associative store, so that a later miss can be served without another memory read.

On a cache miss the cache presents the line address on the lookup port. One cycle later the buffer answers with a hit or a miss. On a hit it returns the full line and its sector-valid mask, and it gives up the entry because the line goes back into the cache. A write from the cache to an address the buffer holds removes that entry, so stale data is never returned. Replacement is first-in first-out. A new victim takes a free slot if there is one, and otherwise displaces the oldest entry, which is dropped silently.

Lookup responses follow a three-state machine. RSP_IDLE means no response. RSP_HIT and RSP_MISS each last one cycle. Every cycle the next state is chosen from the current lookup: no lookup goes to RSP_IDLE, a lookup that finds the line goes to RSP_HIT, and any other lookup goes to RSP_MISS. Evictions fall into four classes: EV_NONE (no eviction), EV_DISCARD (nothing kept, nothing written), EV_KEEP (stored) and EV_SPILL (dirty sectors written back).

Top module: `ro_victim_buf`

## Requirements
- R1: For every eviction, the sectors that are both valid and dirty are driven on the write-back port in the cycle after the eviction, in a single transfer. That transfer carries the line address, the whole line data and a mask whose bit i marks sector i. An eviction with no such sector produces no transfer.
- R2: An evicted line whose read-only flag is low is never stored: occupancy does not change because of it.
- R3: An evicted line is stored only when its read-only flag is high, at least one sector is valid, and no valid sector is dirty. A read-only line that has a valid dirty sector is handled as in R1 and is not stored.
- R4: Each lookup is compared against all stored entries at once. The response arrives exactly one cycle later, with rsp_valid high. On a hit, rsp_hit is high and the line data and sector mask are returned. On a miss, rsp_hit is low. With no lookup, rsp_valid is low.
- R5: An entry that hits is removed: occupancy drops by one and a repeated lookup of that address misses.
- R6: When all entries are valid, a new victim replaces the oldest entry. The oldest entry is lost without any write-back. When a slot is free, no valid entry is displaced.
- R7: A victim whose address is already stored overwrites that entry in place. Occupancy is unchanged, and a later lookup returns the new data and mask.
- R8: A victim and a lookup to the same address in the same cycle produce a hit that returns the victim's data and mask. The line is not kept, and any older copy of that address is removed.
- R9: A write from the cache to a stored address removes that entry. A lookup to the same address in the same cycle misses. A victim to the same address in the same cycle is not stored.
- R10: occupancy equals the number of valid entries, and full is high exactly when occupancy equals DEPTH.
- R11: After reset the buffer is empty, occupancy is 0, full is low, and neither a response nor a write-back is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid | input | 1 | Eviction from the cache this cycle |
| ev_addr | input | AW | Line address of the evicted line |
| ev_sec_valid | input | SECTORS | Per-sector valid flags |
| ev_sec_dirty | input | SECTORS | Per-sector dirty flags |
| ev_ro | input | 1 | Evicted line is read-only |
| ev_data | input | LW | Evicted line data, sector 0 in the low bits |
| lk_valid | input | 1 | Lookup on a cache miss |
| lk_addr | input | AW | Lookup line address |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_mask | output | SECTORS | Sector-valid mask of the returned line |
| rsp_data | output | LW | Returned line data |
| st_valid | input | 1 | Write by the cache to a line |
| st_addr | input | AW | Line address of that write |
| wb_valid | output | 1 | Write-back transfer present |
| wb_addr | output | AW | Write-back line address |
| wb_mask | output | SECTORS | Sectors to write back |
| wb_data | output | LW | Write-back line data |
| occupancy | output | $clog2(DEPTH+1) | Number of valid entries |
| full | output | 1 | All entries valid |

## Verification
Every result of this block falls due exactly one clock edge after its stimulus: the lookup response, the write-back transfer, and the occupancy and full values that follow an insert, hit or invalidation. The bench drives each stimulus on a falling edge and holds it through the rising edge. It samples the outputs on the following falling edge and removes the stimulus at that same point. Because of this, every check reads the single cycle in which a result is due, and the check that follows sees the idle value. Same-cycle collisions (victim with lookup, write with lookup, write with victim) are driven in one cycle and their outcome is read one edge later.

// File: rtl/rovb_pkg.sv
package rovb_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_HIT,
        RSP_MISS
    } rsp_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_DISCARD,
        EV_KEEP,
        EV_SPILL
    } ev_class_e;

    function automatic ev_class_e classify_ev(input logic vld, input logic ro,
                                              input logic any_dirty, input logic any_valid);
        if (!vld)
            return EV_NONE;
        else if (any_dirty)
            return EV_SPILL;
        else if (ro && any_valid)
            return EV_KEEP;
        else
            return EV_DISCARD;
    endfunction

endpackage

// File: rtl/rovb_match.sv
module rovb_match #(
    parameter int DEPTH = 16,
    parameter int AW    = 26
) (
    input  logic [DEPTH-1:0]         ent_valid,
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [AW-1:0]            lk_addr,
    input  logic [AW-1:0]            st_addr,
    input  logic [AW-1:0]            ev_addr,
    output logic [DEPTH-1:0]         lk_match,
    output logic [DEPTH-1:0]         st_match,
    output logic [DEPTH-1:0]         ev_match
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign lk_match[g] = ent_valid[g] && (ent_addr[g] == lk_addr);
        assign st_match[g] = ent_valid[g] && (ent_addr[g] == st_addr);
        assign ev_match[g] = ent_valid[g] && (ent_addr[g] == ev_addr);
    end

endmodule

// File: rtl/rovb_age.sv
module rovb_age #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] ent_valid,
    input  logic [DEPTH-1:0] removed,
    input  logic             ins_new,
    input  logic [DEPTH-1:0] ins_slot,
    output logic [DEPTH-1:0] oldest,
    output logic [DEPTH-1:0] free_slot
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IW-1:0] MAX_AGE = IW'(DEPTH - 1);

    logic [IW-1:0] age_q [DEPTH];
    logic [IW-1:0] dec   [DEPTH];
    logic          found;

    // ages of valid entries always form 0..count-1; oldest carries DEPTH-1 when full
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            dec[j] = '0;
            for (int k = 0; k < DEPTH; k++) begin
                if (removed[k] && (age_q[k] < age_q[j]))
                    dec[j] = dec[j] + 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            oldest[i] = ent_valid[i] && (age_q[i] == MAX_AGE);
    end

    always_comb begin
        free_slot = '0;
        found     = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ent_valid[i] && !found) begin
                free_slot[i] = 1'b1;
                found        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                age_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ins_new && ins_slot[i])
                    age_q[i] <= '0;
                else if (ent_valid[i] && !removed[i])
                    age_q[i] <= age_q[i] - dec[i] + IW'(ins_new);
            end
        end
    end

endmodule

// File: rtl/rovb_wb.sv
module rovb_wb #(
    parameter int AW      = 26,
    parameter int SECTORS = 4,
    parameter int LW      = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spill,
    input  logic [AW-1:0]      ev_addr,
    input  logic [SECTORS-1:0] spill_mask,
    input  logic [LW-1:0]      ev_data,
    output logic               wb_valid,
    output logic [AW-1:0]      wb_addr,
    output logic [SECTORS-1:0] wb_mask,
    output logic [LW-1:0]      wb_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_mask  <= '0;
        end else begin
            wb_valid <= spill;
            wb_mask  <= spill ? spill_mask : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (spill) begin
            wb_addr <= ev_addr;
            wb_data <= ev_data;
        end
    end

endmodule

// File: rtl/ro_victim_buf.sv
module ro_victim_buf
    import rovb_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int SECTORS    = 4,
    parameter int SECT_BYTES = 32,
    parameter int AW         = 26,
    localparam int LW        = SECTORS * SECT_BYTES * 8,
    localparam int OW        = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic [AW-1:0]      ev_addr,
    input  logic [SECTORS-1:0] ev_sec_valid,
    input  logic [SECTORS-1:0] ev_sec_dirty,
    input  logic               ev_ro,
    input  logic [LW-1:0]      ev_data,
    input  logic               lk_valid,
    input  logic [AW-1:0]      lk_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [SECTORS-1:0] rsp_mask,
    output logic [LW-1:0]      rsp_data,
    input  logic               st_valid,
    input  logic [AW-1:0]      st_addr,
    output logic               wb_valid,
    output logic [AW-1:0]      wb_addr,
    output logic [SECTORS-1:0] wb_mask,
    output logic [LW-1:0]      wb_data,
    output logic [OW-1:0]      occupancy,
    output logic               full
);

    logic [DEPTH-1:0]          valid_q, valid_d;
    logic [DEPTH-1:0][AW-1:0]  addr_q;
    logic [SECTORS-1:0]        mask_q [DEPTH];
    logic [LW-1:0]             data_q [DEPTH];
    logic [OW-1:0]             occ_q;

    logic [DEPTH-1:0] lk_match, st_match, ev_match;
    logic [DEPTH-1:0] oldest, free_slot, removed, ins_slot, wr_slot;
    logic [SECTORS-1:0] spill_mask, rd_mask;
    logic [LW-1:0]      rd_data;
    ev_class_e          ev_cls;
    logic keep, spill, ins_req, ins_new, full_now;
    logic lk_st_same, ev_st_same, ev_lk_same, lk_bypass, lk_found;
    rsp_state_e state_q, state_d;

    assign spill_mask = ev_sec_valid & ev_sec_dirty;
    assign ev_cls     = classify_ev(ev_valid, ev_ro, |spill_mask, |ev_sec_valid);
    assign full_now   = &valid_q;

    always_comb begin
        keep  = 1'b0;
        spill = 1'b0;
        unique case (ev_cls)
            EV_NONE:    ;
            EV_DISCARD: ;
            EV_KEEP:    keep  = 1'b1;
            EV_SPILL:   spill = 1'b1;
        endcase
    end

    rovb_match #(.DEPTH(DEPTH), .AW(AW)) i_match (
        .ent_valid (valid_q),
        .ent_addr  (addr_q),
        .lk_addr   (lk_addr),
        .st_addr   (st_addr),
        .ev_addr   (ev_addr),
        .lk_match  (lk_match),
        .st_match  (st_match),
        .ev_match  (ev_match)
    );

    // collision rules: a write wins over everything, a lookup wins over an insert
    assign lk_st_same = st_valid && (st_addr == lk_addr);
    assign ev_st_same = st_valid && (st_addr == ev_addr);
    assign ev_lk_same = lk_valid && (lk_addr == ev_addr);
    assign lk_bypass  = lk_valid && keep && ev_lk_same && !lk_st_same;
    assign lk_found   = lk_valid && (|lk_match) && !lk_st_same;

    assign ins_req  = keep && !ev_lk_same && !ev_st_same;
    assign ins_new  = ins_req && !(|ev_match);
    assign ins_slot = full_now ? oldest : free_slot;
    assign wr_slot  = ins_new ? ins_slot : (ins_req ? ev_match : '0);

    assign removed = (lk_valid ? lk_match : '0)
                   | (st_valid ? st_match : '0)
                   | ((ins_new && full_now) ? oldest : '0);

    assign valid_d = (valid_q & ~removed) | (ins_new ? ins_slot : '0);

    rovb_age #(.DEPTH(DEPTH)) i_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (valid_q),
        .removed   (removed),
        .ins_new   (ins_new),
        .ins_slot  (ins_slot),
        .oldest    (oldest),
        .free_slot (free_slot)
    );

    always_comb begin
        rd_data = '0;
        rd_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lk_match[i]) begin
                rd_data = rd_data | data_q[i];
                rd_mask = rd_mask | mask_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            occ_q   <= '0;
        end else begin
            valid_q <= valid_d;
            occ_q   <= OW'($countones(valid_d));
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_slot[i]) begin
                addr_q[i] <= ev_addr;
                mask_q[i] <= ev_sec_valid;
                data_q[i] <= ev_data;
            end
        end
    end

    // response state machine
    always_comb begin
        if (!lk_valid)
            state_d = RSP_IDLE;
        else if (lk_bypass || lk_found)
            state_d = RSP_HIT;
        else
            state_d = RSP_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RSP_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_mask <= '0;
            rsp_data <= '0;
        end else if (lk_valid) begin
            rsp_mask <= lk_bypass ? ev_sec_valid : (lk_found ? rd_mask : '0);
            rsp_data <= lk_bypass ? ev_data      : (lk_found ? rd_data : '0);
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT:  begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
            RSP_MISS: rsp_valid = 1'b1;
            default:  ;
        endcase
    end

    rovb_wb #(.AW(AW), .SECTORS(SECTORS), .LW(LW)) i_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .spill      (spill),
        .ev_addr    (ev_addr),
        .spill_mask (spill_mask),
        .ev_data    (ev_data),
        .wb_valid   (wb_valid),
        .wb_addr    (wb_addr),
        .wb_mask    (wb_mask),
        .wb_data    (wb_data)
    );

    assign occupancy = occ_q;
    assign full      = full_now;

endmodule

// File: rtl/rovb_chk.sv
module rovb_chk #(
    parameter int DEPTH   = 16,
    parameter int SECTORS = 4,
    parameter int OW      = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ev_valid,
    input logic [SECTORS-1:0] ev_sec_valid,
    input logic [SECTORS-1:0] ev_sec_dirty,
    input logic               ev_ro,
    input logic               lk_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               st_valid,
    input logic               wb_valid,
    input logic [SECTORS-1:0] wb_mask,
    input logic [OW-1:0]      occupancy,
    input logic               full
);

    // R1
    spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && (|(ev_sec_valid & ev_sec_dirty)) |=>
            wb_valid && (wb_mask == $past(ev_sec_valid & ev_sec_dirty)));

    // R1
    no_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_valid && (|(ev_sec_valid & ev_sec_dirty))) |=> !wb_valid);

    // R2
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ro && !lk_valid && !st_valid |=> occupancy == $past(occupancy));

    // R4
    rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R4
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid && !rsp_hit);

    // R10
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy <= OW'(DEPTH)) && (full == (occupancy == OW'(DEPTH))));

    // R6
    stay_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && ev_valid && ev_ro && !(|(ev_sec_valid & ev_sec_dirty)) && (|ev_sec_valid)
            && !lk_valid && !st_valid |=> full);

endmodule

bind ro_victim_buf rovb_chk #(.DEPTH(DEPTH), .SECTORS(SECTORS), .OW(OW)) i_rovb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_valid     (ev_valid),
    .ev_sec_valid (ev_sec_valid),
    .ev_sec_dirty (ev_sec_dirty),
    .ev_ro        (ev_ro),
    .lk_valid     (lk_valid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .st_valid     (st_valid),
    .wb_valid     (wb_valid),
    .wb_mask      (wb_mask),
    .occupancy    (occupancy),
    .full         (full)
);

// File: tb/test_ro_victim_buf.sv
module test_ro_victim_buf;

    localparam int DEPTH = 16, SECTORS = 4, SECT_BYTES = 32, AW = 26;
    localparam int LW = SECTORS * SECT_BYTES * 8;
    localparam int OW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic ev_valid, ev_ro, lk_valid, st_valid;
    logic [AW-1:0] ev_addr, lk_addr, st_addr;
    logic [SECTORS-1:0] ev_sec_valid, ev_sec_dirty;
    logic [LW-1:0] ev_data;
    logic rsp_valid, rsp_hit, wb_valid, full;
    logic [SECTORS-1:0] rsp_mask, wb_mask;
    logic [LW-1:0] rsp_data, wb_data;
    logic [AW-1:0] wb_addr;
    logic [OW-1:0] occupancy;

    int checks = 0;
    int errors = 0;

    ro_victim_buf #(.DEPTH(DEPTH), .SECTORS(SECTORS), .SECT_BYTES(SECT_BYTES), .AW(AW)) i_ro_victim_buf (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_sec_valid(ev_sec_valid),
        .ev_sec_dirty(ev_sec_dirty), .ev_ro(ev_ro), .ev_data(ev_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_mask(rsp_mask), .rsp_data(rsp_data),
        .st_valid(st_valid), .st_addr(st_addr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_mask(wb_mask), .wb_data(wb_data),
        .occupancy(occupancy), .full(full)
    );

    function automatic logic [LW-1:0] mk(input int s);
        logic [LW-1:0] d;
        for (int w = 0; w < LW / 32; w++)
            d[w*32 +: 32] = 32'(s) * 32'h9E3779B1 + 32'(w);
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ev_valid = 0; ev_ro = 0; lk_valid = 0; st_valid = 0;
        ev_addr = '0; lk_addr = '0; st_addr = '0;
        ev_sec_valid = '0; ev_sec_dirty = '0; ev_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic set_ev(input logic [AW-1:0] a, input logic [SECTORS-1:0] v,
                          input logic [SECTORS-1:0] d, input logic ro, input logic [LW-1:0] dat);
        ev_valid = 1; ev_addr = a; ev_sec_valid = v; ev_sec_dirty = d; ev_ro = ro; ev_data = dat;
    endtask

    task automatic insert(input logic [AW-1:0] a, input logic [LW-1:0] dat);
        @(negedge clk);
        set_ev(a, 4'b1111, 4'b0000, 1'b1, dat);
        @(negedge clk);
        idle();
    endtask

    task automatic lookup(input logic [AW-1:0] a, input bit exp_hit, input logic [LW-1:0] exp_d,
                          input logic [SECTORS-1:0] exp_m, input string req);
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        @(negedge clk);
        idle();
        chk(rsp_valid == 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_hit == exp_hit, req, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
        if (exp_hit) begin
            chk(rsp_data == exp_d, req, "rsp_data", rsp_data[63:0], exp_d[63:0]);
            chk(rsp_mask == exp_m, req, "rsp_mask", 64'(rsp_mask), 64'(exp_m));
        end
    endtask

    task automatic chk_occ(input int exp, input string req);
        chk(occupancy == OW'(exp), req, "occupancy", 64'(occupancy), 64'(exp));
        chk(full == (exp == DEPTH), req, "full", 64'(full), 64'(exp == DEPTH));
    endtask

    task automatic t_reset();
        do_reset();
        chk_occ(0, "R11");
        chk(rsp_valid == 0 && wb_valid == 0, "R11", "rsp/wb idle", 64'({rsp_valid, wb_valid}), 64'd0);
        lookup(26'h10, 0, '0, '0, "R11");
    endtask

    task automatic t_spill();
        do_reset();
        @(negedge clk);
        set_ev(26'h55, 4'b1111, 4'b0101, 1'b0, mk(7));
        @(negedge clk);
        idle();
        chk(wb_valid == 1, "R1", "wb_valid", 64'(wb_valid), 64'd1);
        chk(wb_mask == 4'b0101, "R1", "wb_mask", 64'(wb_mask), 64'h5);
        chk(wb_addr == 26'h55, "R1", "wb_addr", 64'(wb_addr), 64'h55);
        chk(wb_data == mk(7), "R1", "wb_data", wb_data[63:0], mk(7) & 64'hFFFFFFFFFFFFFFFF);
        chk_occ(0, "R2");
        @(negedge clk);
        chk(wb_valid == 0, "R1", "wb one cycle", 64'(wb_valid), 64'd0);
        // read-only but dirty: written back, not kept
        set_ev(26'h56, 4'b0011, 4'b0010, 1'b1, mk(8));
        @(negedge clk);
        idle();
        chk(wb_valid == 1 && wb_mask == 4'b0010, "R3", "ro dirty wb", 64'(wb_mask), 64'h2);
        chk_occ(0, "R3");
        lookup(26'h56, 0, '0, '0, "R3");
    endtask

    task automatic t_discard();
        do_reset();
        @(negedge clk);
        set_ev(26'h60, 4'b1111, 4'b0000, 1'b0, mk(9));
        @(negedge clk);
        idle();
        chk(wb_valid == 0, "R2", "no wb on clean", 64'(wb_valid), 64'd0);
        chk_occ(0, "R2");
        lookup(26'h60, 0, '0, '0, "R2");
    endtask

    task automatic t_keep_hit();
        do_reset();
        @(negedge clk);
        set_ev(26'h70, 4'b0011, 4'b0000, 1'b1, mk(11));
        @(negedge clk);
        idle();
        chk(wb_valid == 0, "R3", "no wb on keep", 64'(wb_valid), 64'd0);
        chk_occ(1, "R3");
        lookup(26'h70, 1, mk(11), 4'b0011, "R4");
        chk_occ(0, "R5");
        lookup(26'h70, 0, '0, '0, "R5");
    endtask

    task automatic t_overwrite();
        do_reset();
        insert(26'h80, mk(20));
        insert(26'h80, mk(21));
        chk_occ(1, "R7");
        lookup(26'h80, 1, mk(21), 4'b1111, "R7");
    endtask

    task automatic t_fifo();
        do_reset();
        for (int i = 0; i < DEPTH; i++) insert(AW'(100 + i), mk(100 + i));
        chk_occ(DEPTH, "R10");
        @(negedge clk);
        set_ev(26'd200, 4'b1111, 4'b0000, 1'b1, mk(200));
        @(negedge clk);
        idle();
        chk(wb_valid == 0, "R6", "oldest dropped silently", 64'(wb_valid), 64'd0);
        chk_occ(DEPTH, "R6");
        lookup(26'd100, 0, '0, '0, "R6");
        lookup(26'd101, 1, mk(101), 4'b1111, "R6");
        lookup(26'd200, 1, mk(200), 4'b1111, "R6");
        chk_occ(DEPTH - 2, "R10");
        insert(26'd300, mk(300));
        lookup(26'd102, 1, mk(102), 4'b1111, "R6");
        lookup(26'd300, 1, mk(300), 4'b1111, "R6");
    endtask

    task automatic t_bypass();
        do_reset();
        insert(26'h90, mk(30));
        @(negedge clk);
        set_ev(26'h90, 4'b0110, 4'b0000, 1'b1, mk(31));
        lk_valid = 1; lk_addr = 26'h90;
        @(negedge clk);
        idle();
        chk(rsp_hit == 1, "R8", "bypass hit", 64'(rsp_hit), 64'd1);
        chk(rsp_data == mk(31), "R8", "bypass data", rsp_data[63:0], mk(31) & 64'hFFFFFFFFFFFFFFFF);
        chk(rsp_mask == 4'b0110, "R8", "bypass mask", 64'(rsp_mask), 64'h6);
        chk_occ(0, "R8");
    endtask

    task automatic t_store();
        do_reset();
        insert(26'hA0, mk(40));
        @(negedge clk);
        st_valid = 1; st_addr = 26'hA0;
        @(negedge clk);
        idle();
        chk_occ(0, "R9");
        lookup(26'hA0, 0, '0, '0, "R9");
        insert(26'hA1, mk(41));
        @(negedge clk);
        st_valid = 1; st_addr = 26'hA1; lk_valid = 1; lk_addr = 26'hA1;
        @(negedge clk);
        idle();
        chk(rsp_valid == 1 && rsp_hit == 0, "R9", "write beats lookup", 64'(rsp_hit), 64'd0);
        chk_occ(0, "R9");
        @(negedge clk);
        set_ev(26'hA2, 4'b1111, 4'b0000, 1'b1, mk(42));
        st_valid = 1; st_addr = 26'hA2;
        @(negedge clk);
        idle();
        chk_occ(0, "R9");
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0;
        idle();
        t_reset();
        t_spill();
        t_discard();
        t_keep_hit();
        t_overwrite();
        t_fifo();
        t_bypass();
        t_store();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule